// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Data-Pin Control

This block is a clocked, synthesizable model of the control logic inside a 1M x 4 page-mode DRAM. It watches the asynchronous row strobe, column strobe, write enable and output enable, plus the multiplexed address and the data inputs. All of these pass through a two-stage synchroniser into a fast internal clock, where edges are detected. From the order of those edges it decides what kind of memory cycle is running. It also decides when the data pins drive the last read word, when they stay released, and when input data is written into a small parameterised storage array.

A memory controller under development can run against it as a checkable reference. Each finished cycle raises a one-cycle report carrying an encoded cycle kind. Refresh cycles also report the row that was refreshed, so refresh coverage can be measured. A separate pulse flags write-during-output contention. The model keeps a test-mode state, and an internal row counter serves the column-before-row refresh.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, dq_oe, cyc_vld, refr_vld and test_mode are 0, and the refresh counter is 0, so the first normal column-before-row refresh reports row 0.
- R2: A column strobe fall with we_n high, while a row is open, reads the addressed word. It drives it on dq_out with dq_oe=1 while cas_n and oe_n are low. When cas_n rises it reports kind code 1 (read), provided no write happened in that column cycle.
- R3: we_n low at the column strobe fall sets the early-write flag. dq_in is written at the addressed column, kind code 2 is reported, and dq_oe stays 0 for that whole column cycle.
- R4: we_n falling while cas_n is low, in a column cycle that read and never drove data and with oe_n high, writes dq_in into the latched column and reports kind code 3 (late write).
- R5: we_n falling while cas_n is low after data was driven in that column cycle, with oe_n high, writes dq_in and reports kind code 4 (read-modify-write). Pulling oe_n low again before cas_n rises re-drives the earlier read word, not the new one.
- R6: we_n falling while cas_n and oe_n are both low reports kind code 4 with cyc_illegal=1. The write still happens, and the outputs keep driving the earlier read word.
- R7: dq_oe is 0 whenever cas_n or oe_n has been high for four clocks. Taking oe_n low again while cas_n stays low re-drives the held read word. Once cas_n is high, oe_n has no effect.
- R8: While the row strobe stays low, several column cycles reach different columns of the same open row.
- R9: cas_n low at the row strobe fall with we_n high is a normal refresh: kind code 6, refr_vld=1, and refr_row equal to the counter, which then increments and wraps from 2^ADDR_W-1 to 0.
- R10: cas_n low at the row strobe fall with we_n low reports kind code 7 and sets test_mode. It reports no refreshed row and leaves the counter unchanged.
- R11: A row cycle with no column strobe reports kind code 5 with refr_row equal to its row address. That cycle and a normal refresh (R9) both clear test_mode.
- R12: Holding cas_n low after a read while the row strobe rises and falls again runs a hidden refresh (kind code 6). The outputs keep driving the read word throughout.
- R13: Only the low ROW_SEL row bits and low COL_SEL column bits select a storage word; higher address bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Data presented for writes |
| dq_out | output | DQ_W | Read word held for the data pins |
| dq_oe | output | 1 | Data pins driven when 1, released when 0 |
| cyc_kind | output | 3 | Kind code of the cycle just reported |
| cyc_vld | output | 1 | One-cycle pulse marking a cycle report |
| cyc_illegal | output | 1 | Output/write contention on the reported cycle |
| test_mode | output | 1 | Test mode state |
| refr_row | output | ADDR_W | Row refreshed by the reported cycle |
| refr_vld | output | 1 | refr_row is valid this cycle |

## Verification
The bench uses ADDR_W=10 and DQ_W=4 but shrinks the storage to ROW_SEL=2 and COL_SEL=2, a 16-word array. At that size a write to row 5, column 5 lands on row 1, column 1, which makes the aliasing rule observable. The full 10-bit refresh counter is kept, so a run of 1024 refresh cycles walks it through every row and across its wrap back to 0 within the run budget.

// File: rtl/dram_cyc_pkg.sv
package dram_cyc_pkg;
  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_READ  = 3'd1,
    K_EWR   = 3'd2,
    K_LWR   = 3'd3,
    K_RMW   = 3'd4,
    K_RONLY = 3'd5,
    K_CBR   = 3'd6,
    K_TEST  = 3'd7
  } cyc_kind_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dram_store.sv
module dram_store #(
  parameter int IDX_W = 6,
  parameter int DQ_W  = 4
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DQ_W-1:0]  wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DQ_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DQ_W-1:0] mem [DEPTH];
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/refr_ctr.sv
module refr_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dram_cyc_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DQ_W    = 4,
  parameter int ROW_SEL = 3,
  parameter int COL_SEL = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic [2:0]        cyc_kind,
  output logic              cyc_vld,
  output logic              cyc_illegal,
  output logic              test_mode,
  output logic [ADDR_W-1:0] refr_row,
  output logic              refr_vld
);
  localparam int SW    = 4 + ADDR_W + DQ_W;
  localparam int IDX_W = ROW_SEL + COL_SEL;
  localparam logic [SW-1:0] SYNC_RST = {4'b1111, {(ADDR_W + DQ_W){1'b0}}};

  // synchronised view of every pin
  logic [SW-1:0] syn;
  logic s_ras, s_cas, s_we, s_oe;
  logic [ADDR_W-1:0] s_addr;
  logic [DQ_W-1:0]   s_din;

  strobe_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d({ras_n, cas_n, we_n, oe_n, addr, dq_in}),
    .q(syn)
  );
  assign {s_ras, s_cas, s_we, s_oe, s_addr, s_din} = syn;

  // edge detection
  logic p_ras, p_cas, p_we;
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  always_ff @(posedge clk) begin
    if (rst) {p_ras, p_cas, p_we} <= 3'b111;
    else     {p_ras, p_cas, p_we} <= {s_ras, s_cas, s_we};
  end
  assign ras_fall = p_ras & ~s_ras;
  assign ras_rise = ~p_ras & s_ras;
  assign cas_fall = p_cas & ~s_cas;
  assign cas_rise = ~p_cas & s_cas;
  assign we_fall  = p_we & ~s_we;

  // cycle state
  logic [ADDR_W-1:0]  row_q;
  logic [COL_SEL-1:0] col_q;
  logic open_q, saw_col_q, rd_valid_q, early_q, drove_q, wrote_q;
  cyc_kind_e kind_q;

  logic open_evt, cbr_evt, col_evt, col_rd, col_wr, late_evt, rd_done;
  assign open_evt = ras_fall & s_cas;
  assign cbr_evt  = ras_fall & ~s_cas;
  assign col_evt  = cas_fall & ~s_ras & open_q;
  assign col_rd   = col_evt & s_we;
  assign col_wr   = col_evt & ~s_we;
  assign late_evt = we_fall & ~s_cas & ~cas_fall & ~s_ras & rd_valid_q & ~wrote_q;
  assign rd_done  = cas_rise & rd_valid_q & ~wrote_q;

  // storage
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  assign wr_en  = col_wr | late_evt;
  assign rd_idx = {row_q[ROW_SEL-1:0], s_addr[COL_SEL-1:0]};
  assign wr_idx = col_wr ? rd_idx : {row_q[ROW_SEL-1:0], col_q};

  dram_store #(.IDX_W(IDX_W), .DQ_W(DQ_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(s_din),
    .rd_en(col_rd), .rd_idx(rd_idx), .rd_data(dq_out)
  );

  // refresh row counter
  logic [ADDR_W-1:0] rcnt;
  refr_ctr #(.W(ADDR_W)) u_rctr (
    .clk(clk), .rst(rst), .inc(cbr_evt & s_we), .cnt(rcnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0; col_q <= '0;
      open_q <= 1'b0; saw_col_q <= 1'b0; rd_valid_q <= 1'b0;
      early_q <= 1'b0; drove_q <= 1'b0; wrote_q <= 1'b0;
      kind_q <= K_NONE; cyc_vld <= 1'b0; cyc_illegal <= 1'b0;
      test_mode <= 1'b0; refr_row <= '0; refr_vld <= 1'b0; dq_oe <= 1'b0;
    end else begin
      cyc_vld     <= 1'b0;
      cyc_illegal <= 1'b0;
      refr_vld    <= 1'b0;
      if (open_evt) begin
        row_q <= s_addr; open_q <= 1'b1; saw_col_q <= 1'b0;
      end
      if (ras_rise) begin
        open_q <= 1'b0;
        if (open_q && !saw_col_q) begin
          kind_q <= K_RONLY; cyc_vld <= 1'b1;
          refr_row <= row_q; refr_vld <= 1'b1; test_mode <= 1'b0;
        end
      end
      if (cbr_evt) begin
        open_q <= 1'b0; cyc_vld <= 1'b1;
        if (s_we) begin
          kind_q <= K_CBR; refr_row <= rcnt; refr_vld <= 1'b1; test_mode <= 1'b0;
        end else begin
          kind_q <= K_TEST; test_mode <= 1'b1;
        end
      end
      if (col_evt) begin
        saw_col_q  <= 1'b1;
        col_q      <= s_addr[COL_SEL-1:0];
        early_q    <= ~s_we;
        wrote_q    <= ~s_we;
        rd_valid_q <= s_we;
        drove_q    <= 1'b0;
        if (!s_we) begin
          kind_q <= K_EWR; cyc_vld <= 1'b1;
        end
      end
      if (late_evt) begin
        wrote_q     <= 1'b1;
        cyc_vld     <= 1'b1;
        cyc_illegal <= ~s_oe;
        kind_q      <= (drove_q || !s_oe) ? K_RMW : K_LWR;
      end
      if (rd_done) begin
        kind_q <= K_READ; cyc_vld <= 1'b1;
      end
      if (cas_rise) begin
        rd_valid_q <= 1'b0; early_q <= 1'b0; wrote_q <= 1'b0; drove_q <= 1'b0;
      end
      dq_oe <= ~s_cas & rd_valid_q & ~early_q & ~s_oe;
      if (~s_cas & rd_valid_q & ~early_q & ~s_oe) drove_q <= 1'b1;
    end
  end

  assign cyc_kind = kind_q;
endmodule

// File: rtl/dram_cycle_decoder_chk.sv
module dram_cycle_decoder_chk
  import dram_cyc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cas_n,
  input logic       oe_n,
  input logic       dq_oe,
  input logic [2:0] cyc_kind,
  input logic       cyc_vld,
  input logic       cyc_illegal,
  input logic       test_mode,
  input logic       refr_vld
);
  p_cas_high_z_r7: assert property (@(posedge clk) disable iff (rst)
    (cas_n && $past(cas_n) && $past(cas_n, 2) && $past(cas_n, 3)) |-> !dq_oe);

  p_oe_high_z_r7: assert property (@(posedge clk) disable iff (rst)
    (oe_n && $past(oe_n) && $past(oe_n, 2) && $past(oe_n, 3)) |-> !dq_oe);

  p_early_released_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc_vld && cyc_kind == K_EWR) |-> !dq_oe);

  p_illegal_is_rmw_r6: assert property (@(posedge clk) disable iff (rst)
    cyc_illegal |-> (cyc_vld && cyc_kind == K_RMW));

  p_refresh_kind_r9: assert property (@(posedge clk) disable iff (rst)
    refr_vld |-> (cyc_vld && (cyc_kind == K_CBR || cyc_kind == K_RONLY)));

  p_test_enter_r10: assert property (@(posedge clk) disable iff (rst)
    (cyc_vld && cyc_kind == K_TEST) |-> (test_mode && !refr_vld));

  p_test_exit_r11: assert property (@(posedge clk) disable iff (rst)
    (cyc_vld && (cyc_kind == K_CBR || cyc_kind == K_RONLY)) |-> !test_mode);
endmodule

bind dram_cycle_decoder dram_cycle_decoder_chk u_chk (
  .clk(clk), .rst(rst), .cas_n(cas_n), .oe_n(oe_n), .dq_oe(dq_oe),
  .cyc_kind(cyc_kind), .cyc_vld(cyc_vld), .cyc_illegal(cyc_illegal),
  .test_mode(test_mode), .refr_vld(refr_vld)
);

// File: tb/test_dram_cycle_decoder.sv
module test_dram_cycle_decoder;
  localparam int ADDR_W = 10;
  localparam int DQ_W   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DQ_W-1:0]   dq_in = '0;
  logic [DQ_W-1:0]   dq_out;
  logic              dq_oe;
  logic [2:0]        cyc_kind;
  logic              cyc_vld, cyc_illegal, test_mode, refr_vld;
  logic [ADDR_W-1:0] refr_row;

  always #2.5 clk = ~clk;

  dram_cycle_decoder #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .ROW_SEL(2), .COL_SEL(2)) i_dram_cycle_decoder (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .cyc_kind(cyc_kind), .cyc_vld(cyc_vld), .cyc_illegal(cyc_illegal),
    .test_mode(test_mode), .refr_row(refr_row), .refr_vld(refr_vld)
  );

  typedef struct {
    logic [2:0]        kind;
    logic              ill;
    logic              has_r;
    logic [ADDR_W-1:0] row;
    string             tag;
  } exp_t;

  exp_t exp_q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic expect_evt(input logic [2:0] k, input logic ill, input logic hr,
                            input logic [ADDR_W-1:0] row, input string tag);
    exp_t e;
    e.kind = k; e.ill = ill; e.has_r = hr; e.row = row; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && (cyc_vld || refr_vld)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected cycle report", int'(cyc_kind), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cyc_vld && cyc_kind == e.kind, {e.tag, " kind"}, int'(cyc_kind), int'(e.kind));
        check(cyc_illegal == e.ill, {e.tag, " illegal"}, int'(cyc_illegal), int'(e.ill));
        check(refr_vld == e.has_r, {e.tag, " refr_vld"}, int'(refr_vld), int'(e.has_r));
        if (e.has_r)
          check(refr_row == e.row, {e.tag, " refr_row"}, int'(refr_row), int'(e.row));
      end
    end
  end

  task automatic pins(input logic r, input logic c, input logic w, input logic o);
    ras_n = r; cas_n = c; we_n = w; oe_n = o;
    repeat (6) @(negedge clk);
  endtask

  task automatic drive_chk(input logic [DQ_W-1:0] v, input string tag);
    check(dq_oe === 1'b1, {tag, " dq_oe"}, int'(dq_oe), 1);
    check(dq_out === v, {tag, " dq_out"}, int'(dq_out), int'(v));
  endtask

  task automatic early_wr(input int row, input int col, input logic [DQ_W-1:0] d, input string tag);
    addr = ADDR_W'(row); pins(0, 1, 1, 1);
    addr = ADDR_W'(col); dq_in = d; pins(0, 1, 0, 1);
    expect_evt(3'd2, 0, 0, '0, tag);
    pins(0, 0, 0, 1);
    check(dq_oe == 1'b0, {tag, " early released"}, int'(dq_oe), 0);
    pins(0, 1, 0, 1); pins(1, 1, 0, 1); pins(1, 1, 1, 1);
  endtask

  task automatic rd(input int row, input int col, input logic [DQ_W-1:0] v, input string tag);
    addr = ADDR_W'(row); pins(0, 1, 1, 0);
    addr = ADDR_W'(col); expect_evt(3'd1, 0, 0, '0, tag);
    pins(0, 0, 1, 0);
    drive_chk(v, tag);
    pins(0, 1, 1, 0); pins(1, 1, 1, 1);
  endtask

  task automatic cbr(input logic [ADDR_W-1:0] row, input string tag);
    expect_evt(3'd6, 0, 1, row, tag);
    pins(1, 0, 1, 1); pins(0, 0, 1, 1); pins(1, 0, 1, 1); pins(1, 1, 1, 1);
  endtask

  task automatic enter_test();
    expect_evt(3'd7, 0, 0, '0, "R10 test cbr");
    pins(1, 0, 1, 1); pins(1, 0, 0, 1); pins(0, 0, 0, 1);
    check(test_mode == 1'b1, "R10 test_mode set", int'(test_mode), 1);
    pins(1, 0, 0, 1); pins(1, 1, 1, 1);
    check(test_mode == 1'b1, "R10 test_mode held", int'(test_mode), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dq_oe == 1'b0, "R1 dq_oe", int'(dq_oe), 0);
    check(cyc_vld == 1'b0, "R1 cyc_vld", int'(cyc_vld), 0);
    check(refr_vld == 1'b0, "R1 refr_vld", int'(refr_vld), 0);
    check(test_mode == 1'b0, "R1 test_mode", int'(test_mode), 0);

    // R3 + R8: two early writes in one open row
    addr = 10'd1; pins(0, 1, 1, 1);
    addr = 10'd1; dq_in = 4'hA; pins(0, 1, 0, 1);
    expect_evt(3'd2, 0, 0, '0, "R3/R8 ewr col1");
    pins(0, 0, 0, 1);
    check(dq_oe == 1'b0, "R3 released", int'(dq_oe), 0);
    pins(0, 1, 0, 1);
    addr = 10'd2; dq_in = 4'h3;
    expect_evt(3'd2, 0, 0, '0, "R3/R8 ewr col2");
    pins(0, 0, 0, 1); pins(0, 1, 0, 1); pins(0, 1, 1, 1); pins(1, 1, 1, 1);
    early_wr(0, 0, 4'h5, "R3 ewr r0c0");

    // R2 + R8: page-mode reads
    addr = 10'd1; pins(0, 1, 1, 0);
    addr = 10'd1; expect_evt(3'd1, 0, 0, '0, "R2/R8 rd col1");
    pins(0, 0, 1, 0); drive_chk(4'hA, "R2/R8 col1");
    pins(0, 1, 1, 0);
    addr = 10'd2; expect_evt(3'd1, 0, 0, '0, "R2/R8 rd col2");
    pins(0, 0, 1, 0); drive_chk(4'h3, "R2/R8 col2");
    pins(0, 1, 1, 0); pins(1, 1, 1, 1);
    rd(0, 0, 4'h5, "R2 rd r0c0");

    // R7: output enable control
    addr = 10'd1; pins(0, 1, 1, 0);
    addr = 10'd1; expect_evt(3'd1, 0, 0, '0, "R7 rd");
    pins(0, 0, 1, 0); drive_chk(4'hA, "R7 first");
    pins(0, 0, 1, 1);
    check(dq_oe == 1'b0, "R7 oe high release", int'(dq_oe), 0);
    pins(0, 0, 1, 0); drive_chk(4'hA, "R7 redrive");
    pins(0, 1, 1, 0);
    check(dq_oe == 1'b0, "R7 cas high release", int'(dq_oe), 0);
    pins(1, 1, 1, 0);
    check(dq_oe == 1'b0, "R7 oe ignored", int'(dq_oe), 0);
    pins(1, 1, 1, 1);

    // R4: late write
    addr = 10'd2; pins(0, 1, 1, 1);
    addr = 10'd0; pins(0, 0, 1, 1);
    check(dq_oe == 1'b0, "R4 no drive", int'(dq_oe), 0);
    dq_in = 4'h6; expect_evt(3'd3, 0, 0, '0, "R4 late write");
    pins(0, 0, 0, 1);
    check(dq_oe == 1'b0, "R4 still released", int'(dq_oe), 0);
    pins(0, 1, 0, 1); pins(1, 1, 0, 1); pins(1, 1, 1, 1);
    rd(2, 0, 4'h6, "R4 readback");

    // R5: read-modify-write
    addr = 10'd2; pins(0, 1, 1, 0);
    addr = 10'd0; pins(0, 0, 1, 0); drive_chk(4'h6, "R5 read");
    pins(0, 0, 1, 1);
    dq_in = 4'h9; expect_evt(3'd4, 0, 0, '0, "R5 rmw");
    pins(0, 0, 0, 1);
    check(dq_oe == 1'b0, "R5 released during write", int'(dq_oe), 0);
    pins(0, 0, 0, 0); drive_chk(4'h6, "R5 old data redriven");
    pins(0, 1, 0, 0); pins(1, 1, 0, 1); pins(1, 1, 1, 1);
    rd(2, 0, 4'h9, "R5 readback");

    // R6: contention with oe low
    addr = 10'd0; pins(0, 1, 1, 0);
    addr = 10'd0; pins(0, 0, 1, 0); drive_chk(4'h5, "R6 read");
    dq_in = 4'hC; expect_evt(3'd4, 1, 0, '0, "R6 contention");
    pins(0, 0, 0, 0); drive_chk(4'h5, "R6 held");
    pins(0, 1, 0, 0); pins(1, 1, 0, 1); pins(1, 1, 1, 1);
    rd(0, 0, 4'hC, "R6 readback");

    // R12 + R1: hidden refresh, first refresh row is 0
    addr = 10'd1; pins(0, 1, 1, 0);
    addr = 10'd2;
    expect_evt(3'd6, 0, 1, 10'd0, "R12/R1 hidden cbr");
    expect_evt(3'd1, 0, 0, '0, "R12 read end");
    pins(0, 0, 1, 0); drive_chk(4'h3, "R12 read");
    pins(1, 0, 1, 0); drive_chk(4'h3, "R12 ras high");
    pins(0, 0, 1, 0); drive_chk(4'h3, "R12 during refresh");
    pins(1, 0, 1, 0); pins(1, 1, 1, 0); pins(1, 1, 1, 1);

    // R10 + R11
    enter_test();
    addr = 10'h155; expect_evt(3'd5, 0, 1, 10'h155, "R11 ras-only");
    pins(0, 1, 1, 1); pins(1, 1, 1, 1);
    check(test_mode == 1'b0, "R11 exit by ras-only", int'(test_mode), 0);
    enter_test();
    cbr(10'd1, "R10/R11 counter not advanced");
    check(test_mode == 1'b0, "R11 exit by cbr", int'(test_mode), 0);

    // R13: aliasing
    early_wr(5, 5, 4'h7, "R13 ewr r5c5");
    rd(1, 1, 4'h7, "R13 alias read");

    // R9: counter sweep and wrap
    for (int i = 0; i < 1024; i++) begin
      cbr(ADDR_W'((i + 2) % 1024), "R9 sweep");
    end
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R9 all reports seen", exp_q.size(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule